// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Bank

This block is a bank of general-purpose I/O lines that software controls through a small register bus. Each line has three pins: a pin input, an output value and an output enable. The pad cell outside the block combines them. A data register returns the level of each line. Parameters choose how software drives the outputs. The first scheme writes the data register directly. The second uses a pair of registers that set or clear single lines. The third uses one register as a plain output latch and keeps the data register for input only. An optional direction register sets which lines drive. Its polarity is chosen by parameter: a 1 means "output" in one mode and "input" in the other.

Further parameters set the register width (8, 16, 32 or 64), the line count, and whether line 0 sits at the low or the high end of the word. They also choose whether the set and direction registers read back, and whether the bank is input-only. The bus has no back-pressure. A request is accepted in every cycle in which `bus_req` is high. A read answers exactly one cycle later with `bus_rvalid`, and writes complete at the clock edge that accepts them.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset the output latch is 0 and no line drives (`gpio_oe` all 0 when a direction register exists). In input-enable polarity the direction register therefore resets to all ones.
- R2: A read at offset 0x00 returns the pin levels after a two-flop synchroniser. Three clock edges after a pin change, a read shows the new level.
- R3: In the data-only scheme, a write at offset 0x00 loads the output latch, and `gpio_o` shows the value after that edge.
- R4: In the set/clear scheme, a 1 bit written at offset 0x10 drives its line high and a 1 bit written at offset 0x04 drives it low. 0 bits leave their lines unchanged, and writes at 0x00 do not change the outputs.
- R5: In the set-plus-data scheme, a write at offset 0x10 replaces the output latch, and writes at 0x00 do not change the outputs.
- R6: In output-enable polarity, a 1 written at offset 0x08 makes that line drive. In input-enable polarity, a 1 makes that line an input. Without a direction register, every line drives (`gpio_oe` all ones).
- R7: In normal order, line i is register bit i. In reversed order it is bit REG_W-1-i. Register bits with no line read as 0 and are ignored on write.
- R8: A readable set register returns the cached output latch, not the pins. A readable direction register returns its stored value. When either is write-only, reading it returns 0.
- R9: In input-only mode `gpio_o` and `gpio_oe` stay 0 whatever is written, and data reads still return the pins.
- R10: Reads of offsets that are not implemented in the chosen scheme return 0, and writes to them change nothing.
- R11: Every read request gives `bus_rvalid` high with data on the next cycle, and `bus_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request, accepted every cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | REG_W | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | REG_W | Read data, 0 outside read responses |
| gpio_i | input | NLINES | Pin levels from the pads |
| gpio_o | output | NLINES | Output values to the pads |
| gpio_oe | output | NLINES | Output enables to the pads, 1 = drive |

## Verification
The bench builds four instances on a shared bus, and each one covers a different part of the requirements.
- An 8-bit register with six lines, reversed order, the set/clear scheme and a readable output-enable register. This brings unmapped register bits and full sweeps of the set, clear and direction values into reach.
- An 8-bit set-plus-data instance with a write-only input-enable register and a write-only set register.
- A 16-bit data-only instance without a direction register.
- An 8-bit input-only instance.

All 256 set, clear and direction values are swept on the 8-bit instances, and all 64 pin patterns are swept on the six-line bank.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  typedef enum logic [1:0] {
    WR_DATA_ONLY = 2'd0,
    WR_SET_CLEAR = 2'd1,
    WR_SET_DATA  = 2'd2
  } wr_scheme_e;

  typedef enum logic [1:0] {
    DIR_NONE   = 2'd0,
    DIR_OUT_EN = 2'd1,
    DIR_IN_EN  = 2'd2
  } dir_scheme_e;

  localparam logic [4:0] OFS_DATA = 5'h00;
  localparam logic [4:0] OFS_CLR  = 5'h04;
  localparam logic [4:0] OFS_DIR  = 5'h08;
  localparam logic [4:0] OFS_SET  = 5'h10;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
  parameter int NL           = 8,
  parameter bit INPUT_ONLY   = 1'b0,
  parameter bit DIR_RST_ONES = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic          dir_en,
  input  logic [NL-1:0] wline,
  output logic [NL-1:0] out_q,
  output logic [NL-1:0] dir_q
);
  localparam logic [NL-1:0] DIR_RST = {NL{DIR_RST_ONES}};

  generate
    if (INPUT_ONLY) begin : g_no_out
      assign out_q = '0;
    end else begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_q <= '0;
        else if (load_en) out_q <= wline;
        else if (set_en)  out_q <= out_q | wline;
        else if (clr_en)  out_q <= out_q & ~wline;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= DIR_RST;
    else if (dir_en) dir_q <= wline;
  end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path #(
  parameter int REG_W    = 8,
  parameter int NL       = 8,
  parameter bit REVERSED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             sel_data,
  input  logic             sel_set,
  input  logic             sel_dir,
  input  logic [NL-1:0]    pins_s,
  input  logic [NL-1:0]    out_q,
  input  logic [NL-1:0]    dir_q,
  output logic             rvalid,
  output logic [REG_W-1:0] rdata
);
  function automatic logic [REG_W-1:0] pack(input logic [NL-1:0] v);
    logic [REG_W-1:0] w;
    w = '0;
    for (int b = 0; b < REG_W; b++) begin
      int idx;
      idx = REVERSED ? (REG_W - 1 - b) : b;
      if (idx < NL) w[b] = v[idx];
    end
    return w;
  endfunction

  logic [REG_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (sel_data)     rd_word = pack(pins_s);
    else if (sel_set) rd_word = pack(out_q);
    else if (sel_dir) rd_word = pack(dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_word : '0;
    end
  end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int          REG_W        = 32,
  parameter int          NLINES       = REG_W,
  parameter int          ADDR_W       = 5,
  parameter bit          REVERSED     = 1'b0,
  parameter wr_scheme_e  WR_SCHEME    = WR_SET_CLEAR,
  parameter dir_scheme_e DIR_SCHEME   = DIR_OUT_EN,
  parameter bit          SET_READABLE = 1'b1,
  parameter bit          DIR_READABLE = 1'b1,
  parameter bit          INPUT_ONLY   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NLINES-1:0] gpio_i,
  output logic [NLINES-1:0] gpio_o,
  output logic [NLINES-1:0] gpio_oe
);
  localparam bit HAS_SET = (WR_SCHEME != WR_DATA_ONLY);
  localparam bit HAS_CLR = (WR_SCHEME == WR_SET_CLEAR);
  localparam bit HAS_DIR = (DIR_SCHEME != DIR_NONE);
  localparam bit DIR_INV = (DIR_SCHEME == DIR_IN_EN);

  logic wr_acc, rd_acc;
  logic at_data, at_clr, at_dir, at_set;
  logic load_en, set_en, clr_en, dir_en;
  logic sel_data, sel_set, sel_dir;
  logic [NLINES-1:0] wline, pins_s, out_q, dir_q;

  assign wr_acc  = bus_req & bus_we;
  assign rd_acc  = bus_req & ~bus_we;
  assign at_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign at_clr  = (bus_addr == ADDR_W'(OFS_CLR));
  assign at_dir  = (bus_addr == ADDR_W'(OFS_DIR));
  assign at_set  = (bus_addr == ADDR_W'(OFS_SET));

  // Register word to line order.
  always_comb begin
    wline = '0;
    for (int b = 0; b < REG_W; b++) begin
      int idx;
      idx = REVERSED ? (REG_W - 1 - b) : b;
      if (idx < NLINES) wline[idx] = bus_wdata[b];
    end
  end

  assign load_en = wr_acc & (((WR_SCHEME == WR_DATA_ONLY) & at_data) |
                             ((WR_SCHEME == WR_SET_DATA) & at_set));
  assign set_en  = wr_acc & HAS_CLR & at_set;
  assign clr_en  = wr_acc & HAS_CLR & at_clr;
  assign dir_en  = wr_acc & HAS_DIR & at_dir;

  assign sel_data = at_data;
  assign sel_set  = at_set & HAS_SET & SET_READABLE;
  assign sel_dir  = at_dir & HAS_DIR & DIR_READABLE;

  gpio_sync2 #(.WIDTH(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_i), .q(pins_s)
  );

  gpio_out_regs #(
    .NL(NLINES), .INPUT_ONLY(INPUT_ONLY), .DIR_RST_ONES(DIR_INV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .set_en(set_en),
    .clr_en(clr_en), .dir_en(dir_en), .wline(wline),
    .out_q(out_q), .dir_q(dir_q)
  );

  gpio_read_path #(
    .REG_W(REG_W), .NL(NLINES), .REVERSED(REVERSED)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_acc), .sel_data(sel_data),
    .sel_set(sel_set), .sel_dir(sel_dir), .pins_s(pins_s),
    .out_q(out_q), .dir_q(dir_q), .rvalid(bus_rvalid), .rdata(bus_rdata)
  );

  generate
    if (INPUT_ONLY) begin : g_pins_off
      assign gpio_o  = '0;
      assign gpio_oe = '0;
    end else if (!HAS_DIR) begin : g_pins_bidir
      assign gpio_o  = out_q;
      assign gpio_oe = '1;
    end else if (DIR_INV) begin : g_pins_inen
      assign gpio_o  = out_q;
      assign gpio_oe = ~dir_q;
    end else begin : g_pins_outen
      assign gpio_o  = out_q;
      assign gpio_oe = dir_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk
  import gpio_mmio_pkg::*;
#(
  parameter int          REG_W        = 32,
  parameter int          NLINES       = REG_W,
  parameter int          ADDR_W       = 5,
  parameter wr_scheme_e  WR_SCHEME    = WR_SET_CLEAR,
  parameter dir_scheme_e DIR_SCHEME   = DIR_OUT_EN,
  parameter bit          SET_READABLE = 1'b1,
  parameter bit          INPUT_ONLY   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              bus_rvalid,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [NLINES-1:0] gpio_o,
  input logic [NLINES-1:0] gpio_oe
);
  localparam bit SC = (WR_SCHEME == WR_SET_CLEAR) && !INPUT_ONLY;
  localparam bit NODIR = (DIR_SCHEME == DIR_NONE) && !INPUT_ONLY;

  logic rd_req, known;
  assign rd_req = bus_req && !bus_we;
  assign known  = (bus_addr == ADDR_W'(OFS_DATA)) || (bus_addr == ADDR_W'(OFS_CLR)) ||
                  (bus_addr == ADDR_W'(OFS_DIR))  || (bus_addr == ADDR_W'(OFS_SET));

  assert_reset_out_R1: assert property (@(posedge clk)
    !rst_n |-> gpio_o == '0);

  assert_set_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (SC && bus_req && bus_we && bus_addr == ADDR_W'(OFS_SET) && bus_wdata == '1)
    |=> gpio_o == '1);

  assert_clr_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (SC && bus_req && bus_we && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata == '1)
    |=> gpio_o == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we) |=> ($stable(gpio_o) && $stable(gpio_oe)));

  assert_bidir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    NODIR |-> gpio_oe == '1);

  assert_wo_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!SET_READABLE && rd_req && bus_addr == ADDR_W'(OFS_SET)) |=> bus_rdata == '0);

  assert_input_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    INPUT_ONLY |-> (gpio_o == '0 && gpio_oe == '0));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !known) |=> bus_rdata == '0);

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(
  .REG_W(REG_W), .NLINES(NLINES), .ADDR_W(ADDR_W), .WR_SCHEME(WR_SCHEME),
  .DIR_SCHEME(DIR_SCHEME), .SET_READABLE(SET_READABLE), .INPUT_ONLY(INPUT_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .gpio_o(gpio_o), .gpio_oe(gpio_oe)
);

// File: tb/tb_gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_mmio_ctrl;
  import gpio_mmio_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;

  logic rv_a, rv_b, rv_c, rv_d;
  logic [7:0]  rd_a, rd_b, rd_d;
  logic [15:0] rd_c;
  logic [5:0]  gi_a = '0, go_a, goe_a;
  logic [7:0]  gi_b = '0, go_b, goe_b;
  logic [15:0] gi_c = '0, go_c, goe_c;
  logic [7:0]  gi_d = '0, go_d, goe_d;

  gpio_mmio_ctrl #(.REG_W(8), .NLINES(6), .REVERSED(1'b1), .WR_SCHEME(WR_SET_CLEAR),
    .DIR_SCHEME(DIR_OUT_EN), .SET_READABLE(1'b1), .DIR_READABLE(1'b1), .INPUT_ONLY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata[7:0]), .bus_rvalid(rv_a), .bus_rdata(rd_a),
    .gpio_i(gi_a), .gpio_o(go_a), .gpio_oe(goe_a));

  gpio_mmio_ctrl #(.REG_W(8), .NLINES(8), .REVERSED(1'b0), .WR_SCHEME(WR_SET_DATA),
    .DIR_SCHEME(DIR_IN_EN), .SET_READABLE(1'b0), .DIR_READABLE(1'b0), .INPUT_ONLY(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata[7:0]), .bus_rvalid(rv_b), .bus_rdata(rd_b),
    .gpio_i(gi_b), .gpio_o(go_b), .gpio_oe(goe_b));

  gpio_mmio_ctrl #(.REG_W(16), .NLINES(16), .REVERSED(1'b0), .WR_SCHEME(WR_DATA_ONLY),
    .DIR_SCHEME(DIR_NONE), .SET_READABLE(1'b1), .DIR_READABLE(1'b1), .INPUT_ONLY(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rvalid(rv_c), .bus_rdata(rd_c),
    .gpio_i(gi_c), .gpio_o(go_c), .gpio_oe(goe_c));

  gpio_mmio_ctrl #(.REG_W(8), .NLINES(8), .REVERSED(1'b0), .WR_SCHEME(WR_DATA_ONLY),
    .DIR_SCHEME(DIR_OUT_EN), .SET_READABLE(1'b1), .DIR_READABLE(1'b1), .INPUT_ONLY(1'b1)) dut_d (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata[7:0]), .bus_rvalid(rv_d), .bus_rdata(rd_d),
    .gpio_i(gi_d), .gpio_o(go_d), .gpio_oe(goe_d));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Six-line reversed bank: line i sits at register bit 7-i.
  function automatic logic [7:0] word_a(input logic [5:0] v);
    logic [7:0] w = '0;
    for (int i = 0; i < 6; i++) w[7-i] = v[i];
    return w;
  endfunction
  function automatic logic [5:0] lines_a(input logic [7:0] w);
    logic [5:0] v;
    for (int i = 0; i < 6; i++) v[i] = w[7-i];
    return v;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out a", {10'd0, go_a}, 16'h0);
    chk("R1 oe a", {10'd0, goe_a}, 16'h0);
    chk("R1 oe b", {8'd0, goe_b}, 16'h0);
    chk("R6 oe c bidir", goe_c, 16'hFFFF);
    chk("R9 d reset", {go_d, goe_d}, 16'h0);
    rd(OFS_DIR);
    chk("R1 dir a", {8'd0, rd_a}, 16'h0);
    chk("R11 rvalid", {15'd0, rv_a}, 16'h1);
    @(negedge clk);
    chk("R11 rvalid drop", {15'd0, rv_a}, 16'h0);

    // Set/clear sweep on the reversed six-line bank
    m = '0;
    for (int v = 0; v < 256; v++) begin
      wr(OFS_SET, 16'(v));
      m = m | lines_a(8'(v));
      chk("R4 set", {10'd0, go_a}, {10'd0, m});
      wr(OFS_CLR, 16'(v ^ 8'h5A));
      m = m & ~lines_a(8'(v ^ 8'h5A));
      chk("R4 clr", {10'd0, go_a}, {10'd0, m});
      if (v % 16 == 3) begin
        rd(OFS_SET);
        chk("R8 R7 set readback", {8'd0, rd_a}, {8'd0, word_a(m)});
      end
    end
    wr(OFS_DATA, 16'hFF);
    chk("R4 data write ignored", {10'd0, go_a}, {10'd0, m});
    for (int v = 0; v < 256; v++) begin
      wr(OFS_DIR, 16'(v));
      chk("R6 R7 oe a", {10'd0, goe_a}, {10'd0, lines_a(8'(v))});
      if (v % 32 == 5) begin
        rd(OFS_DIR);
        chk("R8 R7 dir readback", {8'd0, rd_a}, {8'd0, 8'(v) & 8'hFC});
      end
    end
    for (int p = 0; p < 64; p++) begin
      gi_a = 6'(p);
      repeat (3) @(negedge clk);
      rd(OFS_DATA);
      chk("R2 R7 pins a", {8'd0, rd_a}, {8'd0, word_a(6'(p))});
    end
    m = go_a;
    wr(5'h0C, 16'hFF);
    chk("R10 write 0x0C ignored", {10'd0, go_a}, {10'd0, m});
    rd(5'h0C);
    chk("R10 read 0x0C", {8'd0, rd_a}, 16'h0);
    rd(5'h14);
    chk("R10 read 0x14", {8'd0, rd_a}, 16'h0);

    // Set-plus-data bank with write-only set and input-enable direction
    for (int v = 0; v < 256; v++) begin
      wr(OFS_SET, 16'(v));
      chk("R5 set loads", {8'd0, go_b}, 16'(v));
      wr(OFS_DATA, 16'(~v));
      chk("R5 data ignored", {8'd0, go_b}, 16'(v));
      if (v % 32 == 7) begin
        rd(OFS_SET);
        chk("R8 set write-only", {8'd0, rd_b}, 16'h0);
      end
    end
    wr(OFS_CLR, 16'h00FF);
    chk("R10 clr absent b", {8'd0, go_b}, 16'h00FF);
    rd(OFS_CLR);
    chk("R10 clr read b", {8'd0, rd_b}, 16'h0);
    for (int v = 0; v < 256; v++) begin
      wr(OFS_DIR, 16'(v));
      chk("R6 in-enable", {8'd0, goe_b}, {8'd0, ~8'(v)});
    end
    rd(OFS_DIR);
    chk("R8 dir write-only", {8'd0, rd_b}, 16'h0);
    for (int p = 0; p < 256; p += 17) begin
      gi_b = 8'(p);
      repeat (3) @(negedge clk);
      rd(OFS_DATA);
      chk("R2 pins b", {8'd0, rd_b}, 16'(p));
    end

    // Data-only 16-bit bank without direction register
    for (int k = 0; k < 256; k++) begin
      logic [15:0] val;
      val = (16'(k) * 16'h0101) ^ 16'h3C5A;
      wr(OFS_DATA, val);
      chk("R3 data drives", go_c, val);
      chk("R6 bidir oe", goe_c, 16'hFFFF);
    end
    rd(OFS_SET);  chk("R10 set absent c", rd_c, 16'h0);
    rd(OFS_CLR);  chk("R10 clr absent c", rd_c, 16'h0);
    rd(OFS_DIR);  chk("R10 dir absent c", rd_c, 16'h0);
    gi_c = 16'hA5C3;
    repeat (3) @(negedge clk);
    rd(OFS_DATA);
    chk("R2 pins c", rd_c, 16'hA5C3);

    // Input-only bank
    wr(OFS_DATA, 16'hFF); wr(OFS_SET, 16'hFF); wr(OFS_CLR, 16'hFF); wr(OFS_DIR, 16'hFF);
    chk("R9 no drive", {go_d, goe_d}, 16'h0);
    gi_d = 8'h96;
    repeat (3) @(negedge clk);
    rd(OFS_DATA);
    chk("R9 pins still read", {8'd0, rd_d}, 16'h0096);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule